// File: doc/BRIEF.md
# Nine-Bit Serial Character Transmitter

This block sends one asynchronous character each time software writes a byte to its data port. A frame is a low start bit, eight data bits with the least significant bit first, a ninth bit taken from a control register, and a high stop bit. Each bit lasts a fixed number of pulses of a clock-enable, `tick8`, which runs at eight times the baud rate. The divider that makes this enable lies outside the block.

The ninth bit is a control register that keeps its value. Every frame copies it when the frame starts, and it stays the same from frame to frame until software writes it again. It can carry software-computed parity, a ninth data bit, or a second stop level.

While a frame is on the line, an output-enable tells the pad logic to use this block's line instead of the pin's other function. When the frame ends, a transmit-complete flag is set, and it drives an interrupt if the interrupt is enabled. Software can write this flag directly. Writing 1 forces an interrupt. An accepted byte write clears the flag. A byte write that arrives while a frame is in progress is dropped.

Top module: `u9tx_top`

## Requirements
- R1: After reset, `tx_out`=1, `tx_oe`=0, `busy`=0, `done_flag`=0 and `irq`=0.
- R2: When `wr_data` is sampled high while `busy`=0, `busy` and `tx_oe` go high after that edge. `tx_out` then drives a 0 start bit for 8 `tick8` pulses.
- R3: Bit positions 1 to 8 of the frame carry `wr_byte[0]` up to `wr_byte[7]`. Each position lasts 8 `tick8` pulses.
- R4: Bit position 9 carries the ninth-bit control value that was held at the moment the byte write was accepted.
- R5: Bit position 10 is a 1 stop bit lasting 8 ticks. After its last tick, `busy` and `tx_oe` fall and `tx_out` stays 1.
- R6: During a frame, `tx_out` changes only at an edge where `tick8` is high. Without ticks, the frame stalls.
- R7: After the last tick of the frame, `done_flag`=1 and `irq` = `done_flag` AND `irq_en`.
- R8: An accepted byte write clears `done_flag`.
- R9: When `cmp_wr`=1, `done_flag` takes the value of `cmp_val`, and writing 1 raises `irq` when it is enabled. If a software write and the end of a frame fall in the same cycle, the frame end wins and the flag becomes 1.
- R10: A byte write while `busy`=1 is ignored. The frame in progress continues unchanged, and `done_flag` keeps its value.
- R11: The ninth-bit control register changes only when `b9_wr`=1. Frames sent back to back without such a write carry the same ninth bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick8 | input | 1 | Clock-enable at eight times the baud rate |
| wr_data | input | 1 | Data register write strobe |
| wr_byte | input | DATA_W | Character to send |
| b9_wr | input | 1 | Ninth-bit control write strobe |
| b9_val | input | 1 | New ninth-bit control value |
| cmp_wr | input | 1 | Transmit-complete flag write strobe |
| cmp_val | input | 1 | Value written to the flag |
| irq_en | input | 1 | Interrupt enable |
| tx_out | output | 1 | Serial line |
| tx_oe | output | 1 | Selects this line over the pin's other function |
| busy | output | 1 | Frame in progress |
| done_flag | output | 1 | Transmit-complete flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check the following on every cycle:
- a frame always opens with a low start bit and closes on a high level;
- the line holds steady between ticks during a frame;
- an accepted write starts a frame and clears the flag;
- the flag is set whenever a frame ends;
- the flag does not move while idle without a write.

Only the bench's scenarios can show the rest:
- that each bit position carries the correct data or ninth-bit value;
- that a write during a frame leaves that frame's contents intact;
- that the ninth bit persists across frames;
- that the frame end wins over a software clear in the same cycle.

// File: rtl/u9tx_pkg.sv
package u9tx_pkg;
   // start bit + ninth bit + stop bit around the data field
   localparam int unsigned FRAME_OVERHEAD = 3;

   typedef enum logic {
      TXS_IDLE = 1'b0,
      TXS_SEND = 1'b1
   } tx_state_e;

   function automatic int unsigned idx_width(int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/u9tx_pace.sv
// Counts tick8 pulses within one bit time and flags the final one.
module u9tx_pace #(
   parameter int unsigned OSR = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic run,
   input  logic tick,
   output logic bit_end
);
   localparam int unsigned CW = u9tx_pkg::idx_width(OSR);
   localparam bit POW2 = ((OSR & (OSR - 1)) == 0);

   logic [CW-1:0] cnt;

   generate
      if (OSR < 2) begin : g_bad_osr
         $error("u9tx_pace: OSR must be at least 2");
      end
      if (POW2) begin : g_wrap
         // counter wraps naturally at OSR
         always_ff @(posedge clk) begin
            if (!rst_n || clear) cnt <= '0;
            else if (run && tick) cnt <= cnt + 1'b1;
         end
         assign bit_end = run && tick && (&cnt);
      end else begin : g_cmp
         always_ff @(posedge clk) begin
            if (!rst_n || clear) cnt <= '0;
            else if (run && tick) begin
               if (cnt == CW'(OSR - 1)) cnt <= '0;
               else cnt <= cnt + 1'b1;
            end
         end
         assign bit_end = run && tick && (cnt == CW'(OSR - 1));
      end
   endgenerate
endmodule

// File: rtl/u9tx_shift.sv
// Frame shift register: loads the full frame, shifts once per bit time.
module u9tx_shift #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] data,
   input  logic              ninth,
   input  logic              bit_end,
   output logic              busy,
   output logic              line,
   output logic              frame_done
);
   import u9tx_pkg::*;

   localparam int unsigned FW = DATA_W + FRAME_OVERHEAD;
   localparam int unsigned IW = idx_width(FW);

   tx_state_e      state;
   logic [FW-1:0]  sh;
   logic [IW-1:0]  idx;
   logic           last_pos;

   assign last_pos = (idx == IW'(FW - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= TXS_IDLE;
         sh    <= '1;
         idx   <= '0;
      end else if (state == TXS_IDLE) begin
         if (start) begin
            sh    <= {1'b1, ninth, data, 1'b0};
            idx   <= '0;
            state <= TXS_SEND;
         end
      end else if (bit_end) begin
         sh <= {1'b1, sh[FW-1:1]};
         if (last_pos) begin
            state <= TXS_IDLE;
            idx   <= '0;
         end else begin
            idx <= idx + 1'b1;
         end
      end
   end

   assign busy       = (state == TXS_SEND);
   assign line       = busy ? sh[0] : 1'b1;
   assign frame_done = busy && bit_end && last_pos;
endmodule

// File: rtl/u9tx_flag.sv
// Transmit-complete flag with software access and interrupt output.
module u9tx_flag #(
   parameter bit IRQ_REG = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_done,
   input  logic load_clr,
   input  logic sw_wr,
   input  logic sw_val,
   input  logic irq_en,
   output logic flag,
   output logic irq
);
   always_ff @(posedge clk) begin
      if (!rst_n)          flag <= 1'b0;
      else if (frame_done) flag <= 1'b1;    // completion wins
      else if (load_clr)   flag <= 1'b0;
      else if (sw_wr)      flag <= sw_val;
   end

   generate
      if (IRQ_REG) begin : g_irq_ff
         always_ff @(posedge clk) begin
            if (!rst_n) irq <= 1'b0;
            else        irq <= flag && irq_en;
         end
      end else begin : g_irq_comb
         assign irq = flag && irq_en;
      end
   endgenerate
endmodule

// File: rtl/u9tx_top.sv
module u9tx_top #(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned OSR     = 8,
   parameter bit          IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick8,
   input  logic              wr_data,
   input  logic [DATA_W-1:0] wr_byte,
   input  logic              b9_wr,
   input  logic              b9_val,
   input  logic              cmp_wr,
   input  logic              cmp_val,
   input  logic              irq_en,
   output logic              tx_out,
   output logic              tx_oe,
   output logic              busy,
   output logic              done_flag,
   output logic              irq
);
   generate
      if (DATA_W < 1) begin : g_bad_w
         $error("u9tx_top: DATA_W must be positive");
      end
   endgenerate

   logic b9_q;
   logic accept;
   logic bit_end;
   logic frame_done;
   logic busy_i;

   // ninth-bit control keeps its value until rewritten (R11)
   always_ff @(posedge clk) begin
      if (!rst_n)     b9_q <= 1'b0;
      else if (b9_wr) b9_q <= b9_val;
   end

   assign accept = wr_data && !busy_i;

   u9tx_pace #(.OSR(OSR)) u_pace (
      .clk(clk), .rst_n(rst_n), .clear(accept), .run(busy_i),
      .tick(tick8), .bit_end(bit_end)
   );

   u9tx_shift #(.DATA_W(DATA_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .start(accept), .data(wr_byte),
      .ninth(b9_q), .bit_end(bit_end), .busy(busy_i), .line(tx_out),
      .frame_done(frame_done)
   );

   u9tx_flag #(.IRQ_REG(IRQ_REG)) u_flag (
      .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .load_clr(accept),
      .sw_wr(cmp_wr), .sw_val(cmp_val), .irq_en(irq_en),
      .flag(done_flag), .irq(irq)
   );

   assign busy  = busy_i;
   assign tx_oe = busy_i;
endmodule

// File: rtl/u9tx_chk.sv
module u9tx_chk (
   input logic clk,
   input logic rst_n,
   input logic tick8,
   input logic wr_data,
   input logic cmp_wr,
   input logic tx_out,
   input logic busy,
   input logic done_flag
);
   // R2: a frame opens with a low start bit
   assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !tx_out);

   // R5: the last level before the frame ends is the high stop bit
   assert_stop_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(tx_out));

   // R6: no line change inside a frame without a tick
   assert_hold_no_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !tick8) |=> $stable(tx_out));

   // R7: frame end sets the flag
   assert_flag_on_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done_flag);

   // R8: accepted write starts a frame and clears the flag
   assert_accept_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && wr_data) |=> (busy && !done_flag));

   // R9: idle flag moves only through a write
   assert_flag_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !wr_data && !cmp_wr) |=> $stable(done_flag));
endmodule

bind u9tx_top u9tx_chk u_chk (
   .clk(clk), .rst_n(rst_n), .tick8(tick8), .wr_data(wr_data),
   .cmp_wr(cmp_wr), .tx_out(tx_out), .busy(busy), .done_flag(done_flag)
);

// File: tb/sim_u9tx_top.sv
module sim_u9tx_top;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick8 = 1'b0;
   logic       wr_data = 1'b0;
   logic [7:0] wr_byte = '0;
   logic       b9_wr = 1'b0;
   logic       b9_val = 1'b0;
   logic       cmp_wr = 1'b0;
   logic       cmp_val = 1'b0;
   logic       irq_en = 1'b0;
   logic       tx_out, tx_oe, busy, done_flag, irq;

   int checks = 0;
   int errors = 0;
   logic b9_model = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   u9tx_top u0 (
      .clk(clk), .rst_n(rst_n), .tick8(tick8), .wr_data(wr_data),
      .wr_byte(wr_byte), .b9_wr(b9_wr), .b9_val(b9_val), .cmp_wr(cmp_wr),
      .cmp_val(cmp_val), .irq_en(irq_en), .tx_out(tx_out), .tx_oe(tx_oe),
      .busy(busy), .done_flag(done_flag), .irq(irq)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // expected level of frame position k
   function automatic logic exp_bit(input logic [7:0] d, input logic b9, input int k);
      if (k == 0) return 1'b0;
      if (k <= 8) return d[k-1];
      if (k == 9) return b9;
      return 1'b1;
   endfunction

   // starts at a negedge, ends at a negedge
   task automatic give_tick(input int gap);
      tick8 = 1'b1;
      @(posedge clk); @(negedge clk);
      tick8 = 1'b0;
      repeat (gap) @(negedge clk);
   endtask

   task automatic set_b9(input logic v);
      b9_wr = 1'b1; b9_val = v;
      @(negedge clk);
      b9_wr = 1'b0;
      b9_model = v;
   endtask

   task automatic sw_flag(input logic v);
      cmp_wr = 1'b1; cmp_val = v;
      @(negedge clk);
      cmp_wr = 1'b0;
   endtask

   // mode 0 plain, 1 ignored write mid-frame, 2 sw clear at the last tick
   task automatic send(input logic [7:0] d, input int gapmax, input int mode);
      logic b9c;
      b9c = b9_model;
      wr_data = 1'b1; wr_byte = d;
      @(negedge clk);
      wr_data = 1'b0;
      check(busy && tx_oe, "R2 busy/oe after write", {busy, tx_oe}, 3);
      check(!done_flag, "R8 flag cleared by write", done_flag, 0);
      for (int k = 0; k < 11; k++) begin
         for (int j = 0; j < 8; j++) begin
            if (j == 4) begin
               logic e;
               e = exp_bit(d, b9c, k);
               if (k == 0)      check(tx_out == e, "R2 start bit", tx_out, e);
               else if (k <= 8) check(tx_out == e, "R3 data bit", tx_out, e);
               else if (k == 9) check(tx_out == e, "R4 ninth bit", tx_out, e);
               else             check(tx_out == e, "R5 stop bit", tx_out, e);
            end
            if (mode == 1 && k == 5 && j == 2) begin
               sw_flag(1'b1);
               wr_data = 1'b1; wr_byte = ~d;
               @(negedge clk);
               wr_data = 1'b0;
               check(busy == 1'b1, "R10 frame continues", busy, 1);
               check(done_flag == 1'b1, "R10 flag kept", done_flag, 1);
               check(tx_out == exp_bit(d, b9c, k), "R6 line held", tx_out, exp_bit(d, b9c, k));
            end
            if (mode == 2 && k == 10 && j == 7) begin
               cmp_wr = 1'b1; cmp_val = 1'b0;
            end
            give_tick((gapmax > 0) ? int'($urandom_range(gapmax, 0)) : 0);
            cmp_wr = 1'b0;
         end
      end
      check(!busy && !tx_oe && tx_out, "R5 idle after stop", {busy, tx_oe, tx_out}, 1);
      check(done_flag == 1'b1, (mode == 2) ? "R9 end beats sw clear" : "R7 flag set",
            done_flag, 1);
      check(irq == irq_en, "R7 irq follows enable", irq, irq_en);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog expired actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(tx_out == 1'b1, "R1 line idle", tx_out, 1);
      check(tx_oe == 1'b0 && busy == 1'b0, "R1 not busy", {tx_oe, busy}, 0);
      check(done_flag == 1'b0 && irq == 1'b0, "R1 flag clear", {done_flag, irq}, 0);

      // directed: basic frame, ninth bit 1, irq enabled
      irq_en = 1'b1;
      set_b9(1'b1);
      send(8'hA5, 0, 0);
      // R11: ninth bit persists across frames
      send(8'h3C, 1, 0);
      // R9: software clear then software set
      sw_flag(1'b0);
      check(done_flag == 1'b0 && irq == 1'b0, "R9 sw clear", done_flag, 0);
      sw_flag(1'b1);
      check(done_flag == 1'b1 && irq == 1'b1, "R9 sw set raises irq", irq, 1);
      // R6: frame stalls without ticks
      wr_data = 1'b1; wr_byte = 8'h01;
      @(negedge clk);
      wr_data = 1'b0;
      repeat (20) @(negedge clk);
      check(busy && tx_out == 1'b0, "R6 stalled on start bit", tx_out, 0);
      for (int i = 0; i < 88; i++) give_tick(0);
      check(!busy, "R6 frame ends after ticks", busy, 0);
      // R10: write during frame ignored
      set_b9(1'b0);
      send(8'h5A, 1, 1);
      // R9: frame end wins over simultaneous sw clear
      send(8'hFF, 0, 2);
      // random frames
      for (int n = 0; n < 16; n++) begin
         if ($urandom_range(3, 0) == 0) set_b9(1'($urandom_range(1, 0)));
         irq_en = 1'($urandom_range(1, 0));
         send(8'($urandom), 3, 0);
         repeat ($urandom_range(4, 0)) @(negedge clk);
      end
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule